// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

This block is a synthesizable behavioural model of a synchronous burst SRAM. The word is split into byte lanes, and the depth is set by a parameter. Every control input is sampled on the rising clock edge. An access begins when either of two address strobes is low and all three chip enables are active. Later cycles with no strobe either step a two-bit burst counter or repeat the current address. The counter steps in interleaved (XOR) order or in linear (wrapping add) order, as a mode input selects.

A global write stores every lane. The lane write stores only the lanes whose select is low. A second mode input chooses the read path. In flow-through mode, read data comes straight from the array, and the first beat can be sampled two edges after the address. In pipeline mode, read data passes through an output register, and the first beat can be sampled three edges after the address. The output enable and the sleep input gate the data outputs without waiting for a clock edge. Sleep blocks all accesses and leaves the stored contents intact. Tying both mode inputs high gives interleaved pipeline operation.

The read side is a stream with `rd_valid` as its valid flag and no ready signal. The memory cannot hold data back, so each beat is shown for exactly one cycle. A consumer that needs to throttle must do it by controlling the burst: it holds the counter with the advance input high and neither strobe low.

Top module: `burst_sram`

## Requirements
- R1: When `ld_proc_n` or `ld_ctrl_n` is low at an edge, `sleep` is low, and `sel0_n`=0, `sel1`=1, `sel2_n`=0, the address is loaded and accessed in that cycle. If `ld_proc_n` is low, that access is a read whatever the write inputs say. `ld_proc_n` wins when both strobes are low.
- R2: After a load, a cycle with both strobes high and `step_n` low advances a 2-bit count that wraps after four beats. A cycle with both strobes and `step_n` high repeats the current address. The low two address bits are base XOR count when `linear_n`=1, and (base + count) mod 4 when `linear_n`=0. The upper bits stay fixed.
- R3: `all_wr_n` low on a write-capable access stores all lanes of `wr_data`, whatever `lane_wr_n` and `lane_sel_n` say.
- R4: With `all_wr_n` high and `lane_wr_n` low, lane i (bits 8i+7..8i) is written only when `lane_sel_n[i]`=0, and the other lanes keep their contents. With no lane selected, or with both write inputs high, the access is a read.
- R5: With `pipe_mode`=0, the beat for an access sampled at edge k is on `rd_data`/`rd_valid` after edge k.
- R6: With `pipe_mode`=1, that beat appears after edge k+1.
- R7: `rd_data` is zero whenever `rd_valid` is low. `out_en_n` high forces `rd_valid` low at once, and low restores the pending beat, with no clock edge needed.
- R8: A strobe sampled with any chip enable inactive ends the burst. It and the strobe-free cycles after it perform no access. The output goes invalid after that edge in flow-through mode and after the next edge in pipeline mode.
- R9: While `sleep` is high, there are no reads or writes, `rd_valid` is low, the contents are kept, and the burst ends. A load at the first edge after release works normally.
- R10: A read of an address returns the merged result of all earlier full and partial writes to it.
- R11: Reset leaves `rd_valid` low with no burst active, so strobe-free cycles after reset perform no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of control state |
| addr | input | AW | Word address, loaded on a strobe |
| ld_proc_n | input | 1 | Read-only load strobe, active low |
| ld_ctrl_n | input | 1 | Load strobe honouring write inputs, active low |
| step_n | input | 1 | Burst advance, active low |
| sel0_n | input | 1 | Chip enable, active low |
| sel1 | input | 1 | Chip enable, active high |
| sel2_n | input | 1 | Chip enable, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| lane_wr_n | input | 1 | Lane write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| wr_data | input | LANES*LANE_W | Write data |
| pipe_mode | input | 1 | 1 = registered read, 0 = flow-through |
| linear_n | input | 1 | 0 = linear burst order, 1 = interleaved |
| out_en_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Low-power hold, active high |
| rd_data | output | LANES*LANE_W | Read beat |
| rd_valid | output | 1 | Read beat valid |

## Verification
On every cycle, the assertions check the output gating: `out_en_n` and `sleep` silence the bus, and invalid data reads as zero. They also check that a selected read load produces a beat at the flow-through or pipeline distance, and that a deselecting strobe empties the output at the same distances. The bench scenarios cover the behaviours that depend on stored contents. These are the burst address order for both orderings, holds and wrap, and the byte merging under every lane mask. They also include the global override, reads ignoring write inputs, and contents kept across sleep and deselected write attempts.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  localparam int CNT_W = 2;

  typedef logic [CNT_W-1:0] burst_cnt_t;

  // Low address bits for a burst beat: wrapping add or XOR with the count.
  function automatic burst_cnt_t burst_lo(input burst_cnt_t base,
                                          input burst_cnt_t cnt,
                                          input logic       linear);
    return linear ? burst_cnt_t'(base + cnt) : (base ^ cnt);
  endfunction

endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_sram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep,
  input  logic          ld_proc_n,
  input  logic          ld_ctrl_n,
  input  logic          step_n,
  input  logic          chip_on,
  input  logic          linear_n,
  input  logic [AW-1:0] addr,
  output logic          go,
  output logic          wr_ok,
  output logic [AW-1:0] eff_addr
);

  logic          active_q;
  logic [AW-1:0] base_q;
  burst_cnt_t    cnt_q;
  burst_cnt_t    cnt_use;
  logic          load;

  assign load = !ld_proc_n || !ld_ctrl_n;

  always_comb begin
    cnt_use  = step_n ? cnt_q : burst_cnt_t'(cnt_q + burst_cnt_t'(1));
    go       = 1'b0;
    wr_ok    = 1'b0;
    eff_addr = base_q;
    if (!sleep) begin
      if (load) begin
        go       = chip_on;
        wr_ok    = ld_proc_n;
        eff_addr = addr;
      end else if (active_q) begin
        go       = 1'b1;
        wr_ok    = 1'b1;
        eff_addr = {base_q[AW-1:CNT_W],
                    burst_lo(base_q[CNT_W-1:0], cnt_use, !linear_n)};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else if (sleep) begin
      active_q <= 1'b0;
    end else if (load) begin
      active_q <= chip_on;
      base_q   <= addr;
      cnt_q    <= '0;
    end else if (active_q) begin
      cnt_q    <= cnt_use;
    end
  end

endmodule

// File: rtl/lane_array.sv
module lane_array #(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int W     = LANES * LANE_W
) (
  input  logic             clk,
  input  logic [LANES-1:0] wr_be,
  input  logic [AW-1:0]    wr_addr,
  input  logic [W-1:0]     wr_word,
  input  logic [AW-1:0]    rd_addr,
  output logic [W-1:0]     rd_word
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_be[g]) cells[wr_addr] <= wr_word[g*LANE_W +: LANE_W];
    end

    assign rd_word[g*LANE_W +: LANE_W] = cells[rd_addr];
  end

endmodule

// File: rtl/read_stage.sv
module read_stage #(
  parameter int AW = 8,
  parameter int W  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep,
  input  logic          pipe_mode,
  input  logic          out_en_n,
  input  logic          rd_go,
  input  logic [AW-1:0] rd_addr_in,
  output logic [AW-1:0] arr_addr,
  input  logic [W-1:0]  arr_word,
  output logic [W-1:0]  rd_data,
  output logic          rd_valid
);

  logic         acc_v;
  logic         pipe_v;
  logic [W-1:0] pipe_d;
  logic         sel_v;
  logic [W-1:0] sel_d;
  logic         show;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_v    <= 1'b0;
      pipe_v   <= 1'b0;
      arr_addr <= '0;
      pipe_d   <= '0;
    end else begin
      acc_v  <= rd_go;
      pipe_v <= acc_v && !sleep;
      if (rd_go) arr_addr <= rd_addr_in;
      if (acc_v) pipe_d   <= arr_word;
    end
  end

  always_comb begin
    sel_v    = pipe_mode ? pipe_v : acc_v;
    sel_d    = pipe_mode ? pipe_d : arr_word;
    show     = sel_v && !out_en_n && !sleep;
    rd_valid = show;
    rd_data  = show ? sel_d : '0;
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int W     = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             ld_proc_n,
  input  logic             ld_ctrl_n,
  input  logic             step_n,
  input  logic             sel0_n,
  input  logic             sel1,
  input  logic             sel2_n,
  input  logic             all_wr_n,
  input  logic             lane_wr_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic [W-1:0]     wr_data,
  input  logic             pipe_mode,
  input  logic             linear_n,
  input  logic             out_en_n,
  input  logic             sleep,
  output logic [W-1:0]     rd_data,
  output logic             rd_valid
);

  logic             chip_on;
  logic             go;
  logic             wr_ok;
  logic [AW-1:0]    eff_addr;
  logic [LANES-1:0] be;
  logic             rd_go;
  logic [AW-1:0]    arr_addr;
  logic [W-1:0]     arr_word;

  assign chip_on = !sel0_n && sel1 && !sel2_n;

  burst_addr_gen #(.AW(AW)) u_agen (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep    (sleep),
    .ld_proc_n(ld_proc_n),
    .ld_ctrl_n(ld_ctrl_n),
    .step_n   (step_n),
    .chip_on  (chip_on),
    .linear_n (linear_n),
    .addr     (addr),
    .go       (go),
    .wr_ok    (wr_ok),
    .eff_addr (eff_addr)
  );

  // Global write overrides the lane selects; an empty mask means read.
  always_comb begin
    be = '0;
    if (go && wr_ok) begin
      if (!all_wr_n)       be = '1;
      else if (!lane_wr_n) be = ~lane_sel_n;
    end
  end

  assign rd_go = go && (be == '0);

  lane_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk    (clk),
    .wr_be  (be),
    .wr_addr(eff_addr),
    .wr_word(wr_data),
    .rd_addr(arr_addr),
    .rd_word(arr_word)
  );

  read_stage #(.AW(AW), .W(W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep     (sleep),
    .pipe_mode (pipe_mode),
    .out_en_n  (out_en_n),
    .rd_go     (rd_go),
    .rd_addr_in(eff_addr),
    .arr_addr  (arr_addr),
    .arr_word  (arr_word),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

endmodule

// File: rtl/burst_sram_checker.sv
module burst_sram_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sleep,
  input logic         ld_proc_n,
  input logic         ld_ctrl_n,
  input logic         sel0_n,
  input logic         sel1,
  input logic         sel2_n,
  input logic         pipe_mode,
  input logic         out_en_n,
  input logic [W-1:0] rd_data,
  input logic         rd_valid
);

  logic sel_ok;
  logic rd_load;
  logic dsel_load;

  assign sel_ok    = !sel0_n && sel1 && !sel2_n;
  assign rd_load   = !sleep && !ld_proc_n && sel_ok;
  assign dsel_load = !sleep && (!ld_proc_n || !ld_ctrl_n) && !sel_ok;

  assert_oe_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !rd_valid);

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0));

  assert_sleep_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rd_valid);

  assert_flow_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_load && !pipe_mode) |=> (pipe_mode || out_en_n || sleep || rd_valid));

  assert_pipe_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_load && pipe_mode) |=> ##1
      (!pipe_mode || out_en_n || sleep || $past(sleep) || rd_valid));

  assert_deselect_flow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dsel_load |=> (pipe_mode || !rd_valid));

  assert_deselect_pipe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dsel_load |=> ##1 (!pipe_mode || !rd_valid));

endmodule

bind burst_sram burst_sram_checker #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sleep    (sleep),
  .ld_proc_n(ld_proc_n),
  .ld_ctrl_n(ld_ctrl_n),
  .sel0_n   (sel0_n),
  .sel1     (sel1),
  .sel2_n   (sel2_n),
  .pipe_mode(pipe_mode),
  .out_en_n (out_en_n),
  .rd_data  (rd_data),
  .rd_valid (rd_valid)
);

// File: tb/burst_sram_bench.sv
module burst_sram_bench;

  localparam int DEPTH = 256;
  localparam int AW    = 8;
  localparam int LANES = 4;
  localparam int W     = 32;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [AW-1:0]    addr;
  logic             ld_proc_n, ld_ctrl_n, step_n;
  logic             sel0_n, sel1, sel2_n;
  logic             all_wr_n, lane_wr_n;
  logic [LANES-1:0] lane_sel_n;
  logic [W-1:0]     wr_data;
  logic             pipe_mode, linear_n, out_en_n, sleep;
  logic [W-1:0]     rd_data;
  logic             rd_valid;

  int          checks = 0;
  int          errors = 0;
  bit          done   = 0;
  logic [W-1:0] ref_mem [DEPTH];

  always #4 clk = ~clk;

  burst_sram #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(8)) u_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ld_proc_n(ld_proc_n),
    .ld_ctrl_n(ld_ctrl_n), .step_n(step_n), .sel0_n(sel0_n), .sel1(sel1),
    .sel2_n(sel2_n), .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n),
    .lane_sel_n(lane_sel_n), .wr_data(wr_data), .pipe_mode(pipe_mode),
    .linear_n(linear_n), .out_en_n(out_en_n), .sleep(sleep),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [W-1:0] pat(input int a, input int salt);
    logic [W-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*8 +: 8] = 8'(a * 7 + i * 37 + salt * 13 + 11);
    return v;
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string rq, input logic ev, input logic [W-1:0] ed);
    checks++;
    if (rd_valid !== ev || rd_data !== ed) begin
      errors++;
      $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
               rq, rd_valid, rd_data, ev, ed);
    end
  endtask

  task automatic quiet();
    ld_proc_n = 1; ld_ctrl_n = 1; step_n = 1;
    sel0_n = 0; sel1 = 1; sel2_n = 0;
    all_wr_n = 1; lane_wr_n = 1; lane_sel_n = '1; wr_data = '0;
  endtask

  task automatic deselect();
    quiet();
    ld_ctrl_n = 0; sel1 = 0;
  endtask

  task automatic write_word(input logic [AW-1:0] a, input logic glob,
                            input logic [LANES-1:0] mask, input logic [W-1:0] d);
    quiet();
    ld_ctrl_n = 0; addr = a; wr_data = d;
    if (glob) all_wr_n = 0;
    else begin lane_wr_n = 0; lane_sel_n = ~mask; end
    tick();
    for (int i = 0; i < LANES; i++)
      if (glob || mask[i]) ref_mem[a][i*8 +: 8] = d[i*8 +: 8];
  endtask

  task automatic read_word(input logic [AW-1:0] a, input string rq);
    quiet();
    ld_proc_n = 0; addr = a;
    tick();
    if (pipe_mode) begin deselect(); tick(); end
    check(rq, 1'b1, ref_mem[a]);
    deselect();
  endtask

  task automatic run_burst(input logic [AW-1:0] a, input logic lin,
                           input logic [7:0] hold_mask, input int n);
    logic [1:0]    cnt;
    logic [W-1:0]  prev;
    logic [AW-1:0] ea;
    cnt = 0; prev = '0;
    linear_n = !lin;
    for (int j = 0; j < n; j++) begin
      quiet();
      if (j == 0) begin ld_proc_n = 0; addr = a; end
      else begin
        step_n = hold_mask[j];
        if (!hold_mask[j]) cnt = cnt + 2'd1;
      end
      ea = {a[AW-1:2], lin ? 2'(a[1:0] + cnt) : 2'(a[1:0] ^ cnt)};
      tick();
      if (!pipe_mode) check("R2 R5 burst beat", 1'b1, ref_mem[ea]);
      else if (j > 0) check("R2 R6 burst beat", 1'b1, prev);
      prev = ref_mem[ea];
    end
    deselect(); tick();
    if (pipe_mode) check("R6 last beat", 1'b1, prev);
    else check("R8 flow deselect", 1'b0, '0);
    deselect(); tick();
    check("R8 after deselect", 1'b0, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    quiet();
    addr = '0; pipe_mode = 0; linear_n = 1; out_en_n = 0; sleep = 0;
    rst_n = 0;
    repeat (3) tick();
    check("R11 reset output", 1'b0, '0);
    rst_n = 1;
    quiet(); step_n = 0;
    tick();
    check("R11 no burst after reset", 1'b0, '0);

    // Fill every word with a global write.
    for (int a = 0; a < DEPTH; a++) write_word(AW'(a), 1'b1, '0, pat(a, 0));

    // Exhaustive single reads in both read paths.
    pipe_mode = 0;
    for (int a = 0; a < DEPTH; a++) read_word(AW'(a), "R1 R5 flow read");
    deselect(); tick(); pipe_mode = 1; tick();
    for (int a = 0; a < DEPTH; a++) read_word(AW'(a), "R1 R6 pipe read");
    deselect(); tick(); pipe_mode = 0; tick();

    // Every lane mask, then read back the merged word.
    for (int m = 0; m < 16; m++) begin
      write_word(AW'(m * 5 + 3), 1'b0, 4'(m), pat(m, 5));
      read_word(AW'(m * 5 + 3), "R4 R10 lane merge");
    end
    // Global write overrides a partial lane select.
    quiet();
    ld_ctrl_n = 0; addr = 8'd40; all_wr_n = 0; lane_wr_n = 0;
    lane_sel_n = 4'b1110; wr_data = 32'hA1B2C3D4;
    tick();
    ref_mem[40] = 32'hA1B2C3D4;
    read_word(8'd40, "R3 global override");

    // Processor strobe ignores write inputs; it also wins over the other strobe.
    quiet();
    ld_proc_n = 0; ld_ctrl_n = 0; addr = 8'd41; all_wr_n = 0; wr_data = 32'hDEADBEEF;
    tick();
    check("R1 read-only load", 1'b1, ref_mem[41]);
    read_word(8'd41, "R1 contents unchanged");

    // Bursts: every start offset, both orders, both read paths.
    for (int p = 0; p < 2; p++) begin
      deselect(); tick(); pipe_mode = p[0]; tick();
      for (int l = 0; l < 2; l++)
        for (int s = 0; s < 4; s++) begin
          run_burst(AW'(8'h60 + s), l[0], 8'h00, 4);
          run_burst(AW'(8'h90 + s), l[0], 8'b0000_0100, 7);
        end
    end
    deselect(); tick(); pipe_mode = 0; tick();

    // Burst write in linear order from offset 2, then verify each word.
    linear_n = 0;
    quiet(); ld_ctrl_n = 0; addr = 8'hB2; all_wr_n = 0; wr_data = pat(1, 9);
    tick(); ref_mem[8'hB2] = pat(1, 9);
    for (int j = 1; j < 4; j++) begin
      quiet(); step_n = 0; all_wr_n = 0; wr_data = pat(j + 1, 9);
      tick(); ref_mem[{6'b101100, 2'(2 + j)}] = pat(j + 1, 9);
    end
    for (int j = 0; j < 4; j++) read_word(AW'(8'hB0 + j), "R2 burst write order");
    linear_n = 1;

    // Output enable, flow then pipeline.
    quiet(); ld_proc_n = 0; addr = 8'd7; tick();
    check("R7 beat before disable", 1'b1, ref_mem[7]);
    out_en_n = 1; #1;
    check("R7 disabled at once", 1'b0, '0);
    out_en_n = 0; #1;
    check("R7 restored", 1'b1, ref_mem[7]);
    deselect(); tick(); pipe_mode = 1; tick();
    quiet(); ld_proc_n = 0; addr = 8'd9; tick(); deselect();
    out_en_n = 1; tick();
    check("R7 pipeline disabled", 1'b0, '0);
    out_en_n = 0; #1;
    check("R7 pipeline restored", 1'b1, ref_mem[9]);
    deselect(); tick(); pipe_mode = 0; tick();

    // Deselect: each enable alone blocks a write and the following cycles.
    for (int k = 0; k < 3; k++) begin
      quiet(); ld_ctrl_n = 0; addr = 8'd50; all_wr_n = 0; wr_data = 32'h0BADF00D;
      if (k == 0) sel0_n = 1; else if (k == 1) sel1 = 0; else sel2_n = 1;
      tick();
      check("R8 deselected load", 1'b0, '0);
      quiet(); step_n = 0; all_wr_n = 0; wr_data = 32'h0BADF00D;
      tick();
      check("R8 no continuation", 1'b0, '0);
      read_word(8'd50, "R8 write blocked");
    end

    // Sleep in the middle of a burst.
    quiet(); ld_proc_n = 0; addr = 8'd60; tick();
    check("R9 beat before sleep", 1'b1, ref_mem[60]);
    sleep = 1; #1;
    check("R9 sleep silences output", 1'b0, '0);
    quiet(); step_n = 0; tick();
    check("R9 no access asleep", 1'b0, '0);
    quiet(); ld_ctrl_n = 0; addr = 8'd60; all_wr_n = 0; wr_data = 32'h12345678; tick();
    check("R9 write ignored asleep", 1'b0, '0);
    sleep = 0;
    quiet(); step_n = 0; tick();
    check("R9 burst ended by sleep", 1'b0, '0);
    sleep = 1; tick(); sleep = 0;
    quiet(); ld_proc_n = 0; addr = 8'd60; tick();
    check("R9 first load after wake", 1'b1, ref_mem[60]);
    read_word(8'd61, "R10 contents kept");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule